// File: doc/BRIEF.md
# Double-Buffered Clock Register Front End

This block sits between a byte-wide, asynchronous-SRAM-style host bus and a real-time clock counter chain, modelled synchronously on a single clock. The top eight byte addresses of a 2K x 8 space hold the clock registers. In address order they are control/century, seconds, minutes, hour, day, date, month and year. Offset 0 sits at the lowest of those eight addresses, 0x7F8, and offset 7 at 0x7FF. The host never reads the counters directly. It reads a visible copy that this block keeps, and that copy is refreshed from the counters once per second.

The control byte carries two halt bits. Setting the read-halt bit freezes the visible copy so that a multi-byte read is consistent, while the counters keep running. Setting the write-halt bit also freezes the copy and opens the time fields for writing. Clearing that bit hands the staged values to the counter chain through a one-cycle load strobe. Other control bits stop the oscillator, select a 512 Hz test pattern on the seconds LSB, and expose a read-only battery-good flag. The remaining unassigned bits behave as plain storage. A power-fail input blocks every host access and drives a reset output.

Top module: `rtc_shadow_regs`

## Requirements
- R1: Only addresses whose upper bits are all ones (0x7F8..0x7FF by default) reach the registers, with offset = addr[2:0]. Other addresses never drive the bus and never change state.
- R2: The bus is driven (dq_oe=1, dq_out valid in the same cycle) only when cs_n=0, oe_n=0 and we_n=1. A write happens at the rising edge where cs_n=0 and we_n=0, whatever oe_n is.
- R3: While control bits 7 and 6 are both 0, each tick_1hz pulse copies the time fields of cnt_time (byte k = offset k) into the visible registers, readable from the cycle after that edge.
- R4: Control bit 6 = 1 freezes the visible time fields across ticks. After it is cleared, the next tick updates every field at once.
- R5: Control bit 7 = 1 blocks refresh and lets the host write time fields. Writes to time fields while bit 7 is 0 are ignored. Time fields are: control 5:0, seconds 6:0, minutes 6:0, hour 5:0, day 2:0, date 5:0, month 4:0, year 7:0.
- R6: A write to the control byte with bit 7 = 0 while bit 7 was 1 raises load_stb for exactly the one cycle after that edge. At the same time load_time carries the staged time fields, byte k in bits 8k+7:8k, with non-time bits zero.
- R7: Seconds bit 7 is writable at any time, reads back, and drives osc_stop.
- R8: With day bit 6 = 1 and osc_stop = 0, seconds bit 0 reads as a phase bit. The phase is 0 after reset and toggles on each tick_512 pulse taken while this mode is active. Otherwise the stored bit is read.
- R9: Day bit 7 always reads batt_ok, and writes to it are ignored.
- R10: Unassigned bits store and return written data regardless of the halt bits. These are minutes 7, hour 7:6, day 5:3, date 7:6 and month 7:5.
- R11: While pwr_fail = 1, no read drives the bus and no write changes state. rst_out_n is 0 from the cycle after pwr_fail rises to the cycle after it falls.
- R12: After reset, all stored bits are 0, dq_oe = 0, load_stb = 0 and osc_stop = 0. rst_out_n is 0 during reset and 1 three edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Supply out of tolerance; blocks access |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data valid / bus drive |
| tick_1hz | input | 1 | One-second pulse from the counter chain |
| tick_512 | input | 1 | 512 Hz pulse from the counter chain |
| batt_ok | input | 1 | Battery-good level |
| cnt_time | input | 64 | Live counter values, byte k = offset k |
| load_stb | output | 1 | One-cycle commit strobe to the counters |
| load_time | output | 64 | Values committed to the counters |
| osc_stop | output | 1 | Oscillator stop request |
| rst_out_n | output | 1 | Power-fail reset, active low |

## Verification
Read data is combinational from the stored state. Each read is therefore sampled one time step after the bus is driven, in the same low clock phase. A write, tick_1hz or tick_512 pulse is held across one rising edge, so its effect is sampled at the following falling edge. load_stb and rst_out_n each pass one register, so they are checked at the first falling edge after the causing edge. The strobe is checked again one cycle later to confirm that it falls.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
  localparam int NREG   = 8;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = $clog2(NREG);

  localparam int OFF_CTRL = 0;
  localparam int OFF_SEC  = 1;
  localparam int OFF_DAY  = 4;

  localparam int BIT_WHALT = 7;
  localparam int BIT_RHALT = 6;
  localparam int BIT_OSC   = 7;
  localparam int BIT_FT    = 6;
  localparam int BIT_BATT  = 7;

  // bits fed from the counter chain
  function automatic logic [BYTE_W-1:0] time_mask(input int unsigned off);
    case (off)
      0: return 8'h3F;
      1: return 8'h7F;
      2: return 8'h7F;
      3: return 8'h3F;
      4: return 8'h07;
      5: return 8'h3F;
      6: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // bits never stored
  function automatic logic [BYTE_W-1:0] ro_mask(input int unsigned off);
    return (off == OFF_DAY) ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] wr_mask(input int unsigned off, input logic halted);
    return ~ro_mask(off) & (halted ? 8'hFF : ~time_mask(off));
  endfunction

  function automatic logic [NREG*BYTE_W-1:0] time_mask_all();
    logic [NREG*BYTE_W-1:0] m;
    for (int k = 0; k < NREG; k++) m[k*BYTE_W +: BYTE_W] = time_mask(k);
    return m;
  endfunction
endpackage

// File: rtl/rtcfe_decode.sv
module rtcfe_decode #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 3
) (
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic [OFF_W-1:0]  off
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] TOP_TAG = '1;

  logic hit;
  logic access_ok;

  always_comb begin
    hit       = (addr[ADDR_W-1:OFF_W] == TOP_TAG);
    access_ok = !cs_n && !pwr_fail && hit;
    wr_en     = access_ok && !we_n;
    rd_en     = access_ok && we_n && !oe_n;
    off       = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/rtcfe_shadow.sv
module rtcfe_shadow
  import rtcfe_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [OFF_W-1:0]       off,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic                   tick_sec,
  input  logic [NREG*BYTE_W-1:0] cnt_time,
  output logic [NREG*BYTE_W-1:0] vis_flat,
  output logic                   load_stb,
  output logic [NREG*BYTE_W-1:0] load_time
);
  logic [BYTE_W-1:0]      vis_q [NREG];
  logic [BYTE_W-1:0]      vis_d [NREG];
  logic [NREG-1:0]        vis_en;
  logic [NREG*BYTE_W-1:0] staged;
  logic                   whalt;
  logic                   rhalt;
  logic                   refresh;
  logic                   commit;
  logic                   load_stb_q;
  logic [NREG*BYTE_W-1:0] load_time_q;

  always_comb begin
    whalt   = vis_q[OFF_CTRL][BIT_WHALT];
    rhalt   = vis_q[OFF_CTRL][BIT_RHALT];
    refresh = tick_sec && !whalt && !rhalt;
    commit  = wr_en && (off == OFF_W'(OFF_CTRL)) && whalt && !wdata[BIT_WHALT];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam logic [BYTE_W-1:0] TM = time_mask(i);
    logic [BYTE_W-1:0] wm;

    always_comb begin
      wm        = (wr_en && (off == OFF_W'(i))) ? wr_mask(i, whalt) : '0;
      vis_d[i]  = (vis_q[i] & ~wm) | (wdata & wm);
      if (refresh) vis_d[i] = (vis_d[i] & ~TM) | (cnt_time[i*BYTE_W +: BYTE_W] & TM);
      vis_en[i] = (wm != '0) || refresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vis_q[i] <= '0;
      else if (vis_en[i]) vis_q[i] <= vis_d[i];
    end

    assign staged[i*BYTE_W +: BYTE_W]   = vis_d[i] & TM;
    assign vis_flat[i*BYTE_W +: BYTE_W] = vis_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_stb_q <= 1'b0;
    else        load_stb_q <= commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      load_time_q <= '0;
    else if (commit) load_time_q <= staged;
  end

  assign load_stb  = load_stb_q;
  assign load_time = load_time_q;
endmodule

// File: rtl/rtcfe_ftest.sv
module rtcfe_ftest (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_fast,
  input  logic enable,
  output logic phase
);
  logic phase_q;
  logic phase_d;
  logic phase_en;

  always_comb begin
    phase_en = enable && tick_fast;
    phase_d  = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtcfe_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_fail,
  input  logic                   cs_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BYTE_W-1:0]      dq_in,
  output logic [BYTE_W-1:0]      dq_out,
  output logic                   dq_oe,
  input  logic                   tick_1hz,
  input  logic                   tick_512,
  input  logic                   batt_ok,
  input  logic [NREG*BYTE_W-1:0] cnt_time,
  output logic                   load_stb,
  output logic [NREG*BYTE_W-1:0] load_time,
  output logic                   osc_stop,
  output logic                   rst_out_n
);
  logic [1:0]             rsync_q;
  logic                   rst_i_n;
  logic                   rd_en;
  logic                   wr_en;
  logic [OFF_W-1:0]       off;
  logic [NREG*BYTE_W-1:0] vis_flat;
  logic                   ft_run;
  logic                   ft_phase;
  logic [BYTE_W-1:0]      rd_byte;
  logic                   rst_out_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  rtcfe_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .pwr_fail (pwr_fail),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .off      (off)
  );

  rtcfe_shadow u_shadow (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .off       (off),
    .wdata     (dq_in),
    .tick_sec  (tick_1hz),
    .cnt_time  (cnt_time),
    .vis_flat  (vis_flat),
    .load_stb  (load_stb),
    .load_time (load_time)
  );

  assign osc_stop = vis_flat[OFF_SEC*BYTE_W + BIT_OSC];
  assign ft_run   = vis_flat[OFF_DAY*BYTE_W + BIT_FT] && !osc_stop;

  rtcfe_ftest u_ftest (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick_fast (tick_512),
    .enable    (ft_run),
    .phase     (ft_phase)
  );

  always_comb begin
    rd_byte = vis_flat[off*BYTE_W +: BYTE_W];
    if (off == OFF_W'(OFF_DAY)) rd_byte[BIT_BATT] = batt_ok;
    if ((off == OFF_W'(OFF_SEC)) && ft_run) rd_byte[0] = ft_phase;
    dq_out = rd_en ? rd_byte : '0;
    dq_oe  = rd_en;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rst_out_q <= 1'b0;
    else          rst_out_q <= !pwr_fail;
  end
  assign rst_out_n = rst_out_q;
endmodule

// File: rtl/rtc_shadow_regs_chk.sv
module rtc_shadow_regs_chk
  import rtcfe_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pwr_fail,
  input logic                   cs_n,
  input logic                   oe_n,
  input logic                   we_n,
  input logic [OFF_W-1:0]       off,
  input logic [BYTE_W-1:0]      dq_out,
  input logic                   dq_oe,
  input logic                   batt_ok,
  input logic                   load_stb,
  input logic                   rst_out_n,
  input logic                   wr_en,
  input logic [NREG*BYTE_W-1:0] vis_flat
);
  localparam logic [NREG*BYTE_W-1:0] TALL = time_mask_all();

  p_rd_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cs_n && !oe_n && we_n && !pwr_fail));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_flat[BIT_RHALT] && !wr_en) |=> $stable(vis_flat & TALL));

  p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vis_flat[BIT_WHALT]) |-> load_stb);

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  p_batt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && off == OFF_W'(OFF_DAY)) |-> (dq_out[BIT_BATT] == batt_ok));

  p_pf_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !rst_out_n);

  p_pf_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(vis_flat & ~TALL));
endmodule

bind rtc_shadow_regs rtc_shadow_regs_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_fail  (pwr_fail),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .off       (addr[2:0]),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .batt_ok   (batt_ok),
  .load_stb  (load_stb),
  .rst_out_n (rst_out_n),
  .wr_en     (wr_en),
  .vis_flat  (vis_flat)
);

// File: tb/rtc_shadow_regs_tb_top.sv
module rtc_shadow_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_fail = 1'b0;
  logic        cs_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic        tick_1hz = 1'b0;
  logic        tick_512 = 1'b0;
  logic        batt_ok = 1'b1;
  logic [63:0] cnt_time = '0;
  logic        load_stb;
  logic [63:0] load_time;
  logic        osc_stop;
  logic        rst_out_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  rtc_shadow_regs dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .tick_1hz(tick_1hz), .tick_512(tick_512), .batt_ok(batt_ok),
    .cnt_time(cnt_time), .load_stb(load_stb), .load_time(load_time),
    .osc_stop(osc_stop), .rst_out_n(rst_out_n)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CNT = 2'd2, OP_TICK = 2'd3;
  localparam int NVEC = 42;
  // {req[3:0], op[1:0], off[2:0], data[7:0], expect[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd3,  OP_CNT,  3'd1, 8'h25, 8'h00},
    {4'd3,  OP_CNT,  3'd2, 8'h59, 8'h00},
    {4'd3,  OP_CNT,  3'd3, 8'h23, 8'h00},
    {4'd3,  OP_CNT,  3'd7, 8'h99, 8'h00},
    {4'd3,  OP_CNT,  3'd0, 8'h20, 8'h00},
    {4'd3,  OP_TICK, 3'd0, 8'h00, 8'h00},
    {4'd3,  OP_RD,   3'd1, 8'h00, 8'h25},  // R3
    {4'd3,  OP_RD,   3'd2, 8'h00, 8'h59},  // R3
    {4'd3,  OP_RD,   3'd3, 8'h00, 8'h23},  // R3
    {4'd3,  OP_RD,   3'd7, 8'h00, 8'h99},  // R3
    {4'd3,  OP_RD,   3'd0, 8'h00, 8'h20},  // R3
    {4'd4,  OP_WR,   3'd0, 8'h60, 8'h00},
    {4'd4,  OP_RD,   3'd0, 8'h00, 8'h60},  // R4 read halt set, century kept
    {4'd4,  OP_CNT,  3'd1, 8'h26, 8'h00},
    {4'd4,  OP_TICK, 3'd0, 8'h00, 8'h00},
    {4'd4,  OP_RD,   3'd1, 8'h00, 8'h25},  // R4 frozen
    {4'd4,  OP_WR,   3'd0, 8'h00, 8'h00},
    {4'd4,  OP_RD,   3'd1, 8'h00, 8'h25},  // R4 not yet refreshed
    {4'd4,  OP_TICK, 3'd0, 8'h00, 8'h00},
    {4'd4,  OP_RD,   3'd1, 8'h00, 8'h26},  // R4 refreshed
    {4'd4,  OP_RD,   3'd0, 8'h00, 8'h20},  // R4
    {4'd5,  OP_WR,   3'd2, 8'h11, 8'h00},
    {4'd5,  OP_RD,   3'd2, 8'h00, 8'h59},  // R5 write ignored
    {4'd5,  OP_WR,   3'd0, 8'h80, 8'h00},
    {4'd5,  OP_WR,   3'd2, 8'h11, 8'h00},
    {4'd5,  OP_RD,   3'd2, 8'h00, 8'h11},  // R5 write accepted
    {4'd5,  OP_CNT,  3'd2, 8'h33, 8'h00},
    {4'd5,  OP_TICK, 3'd0, 8'h00, 8'h00},
    {4'd5,  OP_RD,   3'd2, 8'h00, 8'h11},  // R5 refresh blocked
    {4'd5,  OP_WR,   3'd0, 8'h99, 8'h00},
    {4'd5,  OP_RD,   3'd0, 8'h00, 8'h99},  // R5 century staged
    {4'd6,  OP_WR,   3'd0, 8'h19, 8'h00},
    {4'd6,  OP_RD,   3'd0, 8'h00, 8'h19},  // R6 after commit
    {4'd10, OP_WR,   3'd3, 8'hC0, 8'h00},
    {4'd10, OP_RD,   3'd3, 8'h00, 8'hE3},  // R10 hour spare bits
    {4'd10, OP_WR,   3'd6, 8'hE0, 8'h00},
    {4'd10, OP_RD,   3'd6, 8'h00, 8'hE0},  // R10 month spare bits
    {4'd9,  OP_WR,   3'd4, 8'h80, 8'h00},
    {4'd9,  OP_RD,   3'd4, 8'h00, 8'h80},  // R9 flag not stored
    {4'd10, OP_WR,   3'd4, 8'h38, 8'h00},
    {4'd10, OP_RD,   3'd4, 8'h00, 8'hB8},  // R10 day spare bits
    {4'd7,  OP_WR,   3'd1, 8'h80, 8'h00}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d, input logic oe = 1'b1);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = a; dq_in = d;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1;
    d = dq_out; oe = dq_oe;
    #1;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_sec();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic pulse_fast();
    @(negedge clk); tick_512 = 1'b1;
    @(negedge clk); tick_512 = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       oe;

    // R12 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R12 rst_out_n in reset", 64'(rst_out_n), 64'd0);
    check("R12 load_stb in reset", 64'(load_stb), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R12 rst_out_n released", 64'(rst_out_n), 64'd1);
    check("R12 dq_oe idle", 64'(dq_oe), 64'd0);
    check("R12 osc_stop", 64'(osc_stop), 64'd0);
    for (int i = 0; i < 8; i++) begin
      bus_read(11'h7F8 + 11'(i), rd, oe);
      check("R12 reset read", 64'(rd), (i == 4) ? 64'h80 : 64'h00);
    end

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] req;
      logic [1:0] op;
      logic [2:0] o;
      logic [7:0] dat;
      logic [7:0] exp;
      {req, op, o, dat, exp} = VEC[v];
      case (op)
        OP_WR:  bus_write(11'h7F8 + 11'(o), dat);
        OP_CNT: cnt_time[o*8 +: 8] = dat;
        OP_TICK: pulse_sec();
        default: begin
          bus_read(11'h7F8 + 11'(o), rd, oe);
          check($sformatf("R%0d table[%0d]", req, v), {55'd0, oe, rd}, {55'd0, 1'b1, exp});
        end
      endcase
    end
    // last row set the stop bit: R7 port check
    check("R7 osc_stop set", 64'(osc_stop), 64'd1);
    bus_read(11'h7F9, rd, oe);
    check("R7 seconds read", 64'(rd), 64'hA6);
    bus_write(11'h7F9, 8'h00);
    check("R7 osc_stop clear", 64'(osc_stop), 64'd0);

    // R6 commit strobe and payload
    bus_write(11'h7F8, 8'h80);
    bus_write(11'h7F9, 8'h45);
    bus_write(11'h7FA, 8'h30);
    bus_write(11'h7FF, 8'h24);
    #1;
    check("R6 no strobe while staging", 64'(load_stb), 64'd0);
    bus_write(11'h7F8, 8'h21);
    #1;
    check("R6 strobe high", 64'(load_stb), 64'd1);
    check("R6 load_time", load_time, 64'h2400_0000_2330_4521);
    @(negedge clk); #1;
    check("R6 strobe one cycle", 64'(load_stb), 64'd0);

    // R8 frequency test phase
    bus_write(11'h7FC, 8'h40);
    bus_read(11'h7F9, rd, oe);
    check("R8 phase 0", 64'(rd), 64'h44);
    pulse_fast();
    bus_read(11'h7F9, rd, oe);
    check("R8 phase 1", 64'(rd), 64'h45);
    pulse_fast();
    bus_read(11'h7F9, rd, oe);
    check("R8 phase back 0", 64'(rd), 64'h44);
    bus_write(11'h7F9, 8'h80);
    pulse_fast();
    bus_read(11'h7F9, rd, oe);
    check("R8 stopped shows stored bit", 64'(rd), 64'hC5);
    bus_write(11'h7F9, 8'h00);
    bus_read(11'h7F9, rd, oe);
    check("R8 phase held while stopped", 64'(rd), 64'h44);

    // R9 flag follows input
    batt_ok = 1'b0;
    bus_read(11'h7FC, rd, oe);
    check("R9 flag low", 64'(rd), 64'h40);
    batt_ok = 1'b1;

    // R1 decode
    bus_read(11'h7F0, rd, oe);
    check("R1 no drive outside", 64'(oe), 64'd0);
    bus_write(11'h3F9, 8'h80);
    check("R1 no write outside", 64'(osc_stop), 64'd0);

    // R2 mode decode
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 11'h7F9;
    #1;
    check("R2 no drive with oe_n high", 64'(dq_oe), 64'd0);
    cs_n = 1'b1;
    bus_write(11'h7F9, 8'h80, 1'b0);
    check("R2 write with oe_n low", 64'(osc_stop), 64'd1);
    bus_write(11'h7F9, 8'h00);

    // R11 power fail
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); #1;
    check("R11 reset out asserted", 64'(rst_out_n), 64'd0);
    bus_write(11'h7F9, 8'h80);
    check("R11 write blocked", 64'(osc_stop), 64'd0);
    bus_read(11'h7F9, rd, oe);
    check("R11 read blocked", 64'(oe), 64'd0);
    @(negedge clk); pwr_fail = 1'b0;
    @(negedge clk); #1;
    check("R11 reset out released", 64'(rst_out_n), 64'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule